// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Interface

This block is the digital front end of a four-channel digital-to-analog converter that is programmed over a serial link. A host frames each command with an active-low select, clocks the bits in most-significant first, and releases the select. On that release the block decodes the frame. The frame either writes a code into one channel's input register, powers down one channel, or powers down all four. Each channel keeps an input register and a DAC register behind it. A level-sensitive, active-low update strobe lets the DAC registers follow their input registers, or holds them frozen so that all channels can change together.

The serial pins are sampled by the block's system clock, which must run at least twice as fast as the serial clock. Edges are found by comparing each sample with the one taken before it. The block drives one code bus per channel and one power-down flag per channel. A channel's code reads as zero while that channel is powered down. The code width is a parameter. The frame width follows from it, so a 10-bit variant with a 14-bit frame uses the same source.

Top module: `dacif_quad`

## Requirements
- R1: While `csel_n` is low, each rising edge of `sclk` shifts `sdin` into the frame register LSB-side, so the first bit sent ends up as the MSB. While `csel_n` is high the register holds. An `sclk` rise in the same cycle as the `csel_n` rise is not shifted.
- R2: Decoding happens only on a rising edge of `csel_n`. The 16-bit frame, from MSB down, is: all-off flag (bit 15), one-off flag (bit 14), channel address (bits 13:12), code (bits 11:0). A frame of more than 16 clocks keeps only the last 16 bits.
- R3: A frame with both flags at 0 writes the code into the input register of the addressed channel and clears that channel's power-down flag. Address 0 selects channel A (`dac_code_o[11:0]`), 1 selects B, 2 selects C and 3 selects D (`dac_code_o[47:36]`).
- R4: A frame with the all-off flag at 1 sets all four power-down flags, whatever its address bits hold.
- R5: A frame with the all-off flag at 0 and the one-off flag at 1 sets only the power-down flag of the addressed channel.
- R6: While `upd_n` is low, each DAC register takes its input register's value, including a value written in the same cycle. While `upd_n` is high the DAC registers hold.
- R7: Each channel's `dac_code_o` slice equals its DAC register value, or zero while its `shdn_o` bit is 1.
- R8: Reset clears every input register, every DAC register and every power-down flag.
- R9: Input and DAC registers keep updating while a channel is powered down. The stored code appears on the output as soon as the channel's flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| sdin | input | 1 | Serial data, MSB first |
| upd_n | input | 1 | Active-low level update strobe for the DAC registers |
| dac_code_o | output | NCH*DATA_W (48) | Channel codes, channel A in the low slice |
| shdn_o | output | NCH (4) | Power-down flag of each channel, bit 0 = A |

## Verification
Two functions can act in the same cycle: the commit of a frame into an input register on the select rise, and the update strobe's transparency or hold decision for the DAC register. The bench provokes this by committing frames with `upd_n` already low, with it high, and by dropping it after a held load. The DAC register must take the new code in the commit cycle in the first case and keep the old one in the second. A second collision is a serial clock rise in the same cycle as the select rise. The bench judges it by choosing bits whose wrongly shifted frame would decode as a load, while the correctly held frame decodes as an all-off command. A cycle-accurate behavioural model is compared with every output on every clock.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // Command carried by a committed frame
    typedef enum logic [1:0] {
        CMD_LOAD     = 2'd0,
        CMD_SHDN_ONE = 2'd1,
        CMD_SHDN_ALL = 2'd2
    } dacif_cmd_e;

endpackage

// File: rtl/dacif_shift.sv
module dacif_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csel_n,
    input  logic               sclk,
    input  logic               sdin,
    output logic [FRAME_W-1:0] word_o,
    output logic               commit_o
);

    typedef struct packed {
        logic               sclk;
        logic               csel;
        logic [FRAME_W-1:0] sr;
    } shift_t;

    shift_t s_d, s_q;
    logic   sclk_rise;

    always_comb begin
        s_d       = s_q;
        sclk_rise = sclk & ~s_q.sclk;
        commit_o  = csel_n & ~s_q.csel;
        s_d.sclk  = sclk;
        s_d.csel  = csel_n;
        if (!csel_n && sclk_rise) begin
            s_d.sr = {s_q.sr[FRAME_W-2:0], sdin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk <= 1'b0;
            s_q.csel <= 1'b1;   // idle high, so no commit right after reset
            s_q.sr   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = s_q.sr;

    // R1: select high freezes the frame register
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        csel_n |=> s_q.sr == $past(s_q.sr));

    // R1: a sampled rising serial edge with select low shifts in one bit
    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!csel_n && sclk && !s_q.sclk) |=>
            (s_q.sr[0] == $past(sdin)) &&
            (s_q.sr[FRAME_W-1:1] == $past(s_q.sr[FRAME_W-2:0])));

endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 2,
    localparam int NCH     = 1 << ADDR_W,
    localparam int FRAME_W = DATA_W + 2 + ADDR_W
) (
    input  logic [FRAME_W-1:0] word_i,
    input  logic               commit_i,
    output logic [NCH-1:0]     load_o,
    output logic [NCH-1:0]     shdn_set_o,
    output logic [DATA_W-1:0]  data_o
);

    logic              all_off;
    logic              one_off;
    logic [ADDR_W-1:0] addr;
    logic [NCH-1:0]    sel;
    dacif_cmd_e        cmd;

    always_comb begin
        all_off = word_i[FRAME_W-1];
        one_off = word_i[FRAME_W-2];
        addr    = word_i[FRAME_W-3 -: ADDR_W];
        data_o  = word_i[DATA_W-1:0];

        if (all_off) begin
            cmd = CMD_SHDN_ALL;
        end else if (one_off) begin
            cmd = CMD_SHDN_ONE;
        end else begin
            cmd = CMD_LOAD;
        end

        sel       = '0;
        sel[addr] = 1'b1;

        load_o     = '0;
        shdn_set_o = '0;
        if (commit_i) begin
            unique case (cmd)
                CMD_LOAD:     load_o     = sel;
                CMD_SHDN_ONE: shdn_set_o = sel;
                CMD_SHDN_ALL: shdn_set_o = '1;
                default:      load_o     = '0;
            endcase
        end
    end

    // R3: a load touches at most one channel and never coincides with a power-down
    always_comb begin
        a_r3_one_load: assert ($onehot0(load_o));
        a_r3_excl:     assert ((load_o & shdn_set_o) == '0);
    end

endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shdn_set_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              upd_n,
    output logic [DATA_W-1:0] code_o,
    output logic              shdn_o
);

    typedef struct packed {
        logic [DATA_W-1:0] inreg;
        logic [DATA_W-1:0] dac;
        logic              shdn;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load_i) begin
            c_d.inreg = data_i;
        end
        if (shdn_set_i) begin
            c_d.shdn = 1'b1;
        end else if (load_i) begin
            c_d.shdn = 1'b0;
        end
        // strobe low: behaves as a transparent latch on the input register
        if (!upd_n) begin
            c_d.dac = c_d.inreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign code_o = c_q.shdn ? '0 : c_q.dac;
    assign shdn_o = c_q.shdn;

    // R6: strobe high holds the DAC register
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        upd_n |=> c_q.dac == $past(c_q.dac));

    // R6: a load with the strobe low reaches the DAC register in the same cycle
    a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !upd_n) |=> c_q.dac == $past(data_i));

    // R3: a load wakes the channel
    a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !c_q.shdn);

    // R5: a power-down command sets the flag
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_set_i |=> c_q.shdn);

    // R9: a powered-down channel still tracks its input register while transparent
    a_r9_track: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.shdn && !upd_n && !load_i) |=> c_q.dac == $past(c_q.inreg));

endmodule

// File: rtl/dacif_quad.sv
module dacif_quad #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 2,
    localparam int NCH     = 1 << ADDR_W,
    localparam int FRAME_W = DATA_W + 2 + ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csel_n,
    input  logic                  sclk,
    input  logic                  sdin,
    input  logic                  upd_n,
    output logic [NCH*DATA_W-1:0] dac_code_o,
    output logic [NCH-1:0]        shdn_o
);

    logic [FRAME_W-1:0] word;
    logic               commit;
    logic [NCH-1:0]     load;
    logic [NCH-1:0]     shdn_set;
    logic [DATA_W-1:0]  data;

    dacif_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .csel_n   (csel_n),
        .sclk     (sclk),
        .sdin     (sdin),
        .word_o   (word),
        .commit_o (commit)
    );

    dacif_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .word_i     (word),
        .commit_i   (commit),
        .load_o     (load),
        .shdn_set_o (shdn_set),
        .data_o     (data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dacif_channel #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[g]),
            .shdn_set_i (shdn_set[g]),
            .data_i     (data),
            .upd_n      (upd_n),
            .code_o     (dac_code_o[g*DATA_W +: DATA_W]),
            .shdn_o     (shdn_o[g])
        );
    end

    // R4: an all-off frame powers down every channel
    a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[FRAME_W-1]) |=> (shdn_o == '1));

    // R2: without a commit the power-down flags only fall through a load, never rise
    a_r2_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ((shdn_o & ~$past(shdn_o)) == '0));

endmodule

// File: tb/test_dacif_quad.sv
`timescale 1ns/1ps
module test_dacif_quad;

    localparam int DW  = 12;
    localparam int NCH = 4;
    localparam int FW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic upd_n = 1'b1;
    logic [NCH*DW-1:0] dac_code;
    logic [NCH-1:0]    shdn;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dacif_quad i_dacif_quad (
        .clk        (clk),
        .rst_n      (rst_n),
        .csel_n     (csel_n),
        .sclk       (sclk),
        .sdin       (sdin),
        .upd_n      (upd_n),
        .dac_code_o (dac_code),
        .shdn_o     (shdn)
    );

    // ---------------- behavioural reference ----------------
    int m_shift;
    int m_in  [NCH];
    int m_dac [NCH];
    bit m_sd  [NCH];
    bit m_sclk_p;
    bit m_cs_p;

    always @(posedge clk) begin
        bit srise, crise;
        int w, ch;
        if (!rst_n) begin
            m_shift = 0; m_sclk_p = 0; m_cs_p = 1;
            for (int i = 0; i < NCH; i++) begin
                m_in[i] = 0; m_dac[i] = 0; m_sd[i] = 0;
            end
        end else begin
            srise = sclk && !m_sclk_p;
            crise = csel_n && !m_cs_p;
            w = m_shift;
            if (!csel_n && srise) m_shift = ((m_shift << 1) | int'(sdin)) & 16'hFFFF;
            if (crise) begin
                ch = (w >> 12) & 3;
                if (w & 16'h8000) begin
                    for (int i = 0; i < NCH; i++) m_sd[i] = 1;
                end else if (w & 16'h4000) begin
                    m_sd[ch] = 1;
                end else begin
                    m_in[ch] = w & 12'hFFF;
                    m_sd[ch] = 0;
                end
            end
            if (!upd_n) begin
                for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
            end
            m_sclk_p = sclk;
            m_cs_p   = csel_n;
        end
    end

    // every-cycle comparison against the model (R1/R6/R7)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                int exp_code;
                exp_code = m_sd[i] ? 0 : m_dac[i];
                n_run++;
                if (int'(dac_code[i*DW +: DW]) != exp_code || shdn[i] != m_sd[i]) begin
                    n_fail++;
                    $display("FAIL model R7 ch%0d code act=%0h exp=%0h shdn act=%0b exp=%0b",
                             i, dac_code[i*DW +: DW], exp_code, shdn[i], m_sd[i]);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic int code_of(int ch);
        return int'(dac_code[ch*DW +: DW]);
    endfunction

    function automatic logic [FW-1:0] mk(bit sa, bit sd, int addr, int data);
        return {sa, sd, 2'(addr), 12'(data)};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(bit b);
        @(negedge clk); sdin = b; sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
    endtask

    task automatic frame(logic [31:0] bits, int n);
        @(negedge clk); csel_n = 1'b0;
        for (int i = n - 1; i >= 0; i--) sbit(bits[i]);
        @(negedge clk); sclk = 1'b0;
        @(negedge clk); csel_n = 1'b1;
        tick(2);
    endtask

    task automatic send(logic [FW-1:0] w);
        frame({16'h0, w}, FW);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R8: reset state
        for (int i = 0; i < NCH; i++) chk("R8 reset code", code_of(i), 0);
        chk("R8 reset shdn", int'(shdn), 0);

        // R6 hold, then transparency; R3 address 0 -> A
        upd_n = 1'b1;
        send(mk(0, 0, 0, 12'h123));
        chk("R6 held while strobe high", code_of(0), 0);
        upd_n = 1'b0;
        tick(2);
        chk("R6 transparent after strobe low", code_of(0), 12'h123);

        // R3 loads with strobe already low: same-cycle pass-through
        send(mk(0, 0, 2, 12'hABC));
        chk("R3 load C", code_of(2), 12'hABC);
        chk("R3 B untouched", code_of(1), 0);
        send(mk(0, 0, 1, 12'h0F0));
        send(mk(0, 0, 3, 12'hFFF));
        chk("R3 load B", code_of(1), 12'h0F0);
        chk("R3 load D", code_of(3), 12'hFFF);

        // R1: clocks with select high are not shifted; a bare select pulse re-commits
        for (int i = 0; i < 20; i++) sbit(1'b0);
        @(negedge clk); sclk = 1'b0; csel_n = 1'b0;
        @(negedge clk); csel_n = 1'b1;
        tick(2);
        chk("R1 no shift with select high, A", code_of(0), 12'h123);
        chk("R1 held frame recommitted, D", code_of(3), 12'hFFF);

        // R2: overlong frame keeps the last 16 bits
        frame({12'h0, 4'hF, mk(0, 0, 1, 12'h5A5)}, 20);
        chk("R2 overlong frame B", code_of(1), 12'h5A5);
        chk("R2 overlong no shutdown", int'(shdn), 0);

        // R1: serial rise coincident with select rise is not shifted
        begin
            logic [14:0] b;
            b = 15'h0333;
            @(negedge clk); csel_n = 1'b0;
            for (int i = 14; i >= 0; i--) sbit(b[i]);
            @(negedge clk); sdin = 1'b0; sclk = 1'b0;
            @(negedge clk); sclk = 1'b1; csel_n = 1'b1;
            @(negedge clk); sclk = 1'b0;
            tick(2);
        end
        chk("R1 coincident edge not shifted", int'(shdn), 4'hF);

        // R9: registers move while powered down, output shows them on wake
        upd_n = 1'b1;
        send(mk(0, 0, 2, 12'h246));
        chk("R3 wake C shows held DAC", code_of(2), 12'hABC);
        send(mk(1, 0, 0, 12'h000));
        upd_n = 1'b0;
        tick(2);
        chk("R9 C gated during shutdown", code_of(2), 0);
        upd_n = 1'b1;
        tick(1);
        send(mk(0, 0, 2, 12'h246));
        chk("R9 C shows code written during shutdown", code_of(2), 12'h246);

        // R5: selective power-down
        upd_n = 1'b0;
        send(mk(0, 0, 0, 12'h111));
        send(mk(0, 0, 1, 12'h222));
        send(mk(0, 0, 3, 12'h333));
        chk("R7 all awake", int'(shdn), 0);
        send(mk(0, 1, 1, 12'hFFF));
        chk("R5 only B off", int'(shdn), 4'b0010);
        chk("R7 B gated", code_of(1), 0);
        chk("R5 D untouched", code_of(3), 12'h333);

        // R4: all-off ignores its address
        send(mk(1, 0, 2, 12'h999));
        chk("R4 all off", int'(shdn), 4'hF);

        // R8: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R8 reset clears shdn", int'(shdn), 0);
        for (int i = 0; i < NCH; i++) chk("R8 reset clears code", code_of(i), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        done = 1;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule